// File: doc/BRIEF.md
# Network Message Launcher

This block builds outgoing network messages and sends them as one unbroken stream. The processor first stores words into a small descriptor register file through a write port that behaves like a cache write hit. The first slot holds the header, which carries a message opcode and a destination node. The next slots hold explicit data words. These are followed by address/length pairs, and each pair names a block of memory that the block reads and appends to the message.

A single launch command gives two counts: the number of descriptor slots in use and how many of them are explicit words, with the header counted as explicit. The block checks the shape of the descriptor and the privilege of the header opcode before it sends anything. A launch is therefore either streamed whole on the valid/ready output, with a flag on its final word, or rejected with a one-cycle fault pulse. While a message is in flight, descriptor writes and further launches are held off, so the message always matches the descriptor at launch.

A small stub on the receive side queues incoming words. It raises an interrupt line while the queue is not empty and lets the processor read and pop the head word directly.

Top module: `msg_launcher`

## Requirements
- R1: After reset, out_valid, launch_fault, rx_irq and dw_hold are 0, launch_ready is 1 and every descriptor slot reads 0.
- R2: When dw_valid is 1 and dw_hold is 0, dw_data is stored in slot dw_idx at the clock edge, and a later message carries the new value.
- R3: An accepted launch (launch_valid and launch_ready at an edge) makes out_valid 1 from the next cycle. The first nexp output words are slots 0 to nexp-1 in order, and the header opcode sits in bits 63:56 of slot 0.
- R4: Slots nexp to len-1 form pairs: the even offset from nexp holds a word address in bits 31:0, and the next slot holds a word count in bits 7:0. For each pair in order, memory words addr to addr+count-1 are appended. A zero count appends nothing.
- R5: out_last is 1 on the final word of a message only, and out_valid is 0 in the cycle after that word is accepted.
- R6: When user_mode is 1 and the header opcode is at least 0xC0, the launch raises launch_fault for exactly one cycle after the accepting edge and emits no word. With user_mode 0, the same descriptor is sent.
- R7: A launch with nexp = 0, nexp > len, len > 8 or an odd len-nexp raises launch_fault for one cycle and emits no word.
- R8: From the accepting edge until the final word is accepted, dw_hold is 1 and launch_ready is 0, and descriptor writes are dropped. dw_hold is also 1 in any cycle where launch_valid is 1.
- R9: While out_ready is 0, out_valid, out_data and out_last hold their values, and no word is lost or repeated.
- R10: Received words are queued up to 4 deep and read back in arrival order at cpu_rx_data, with cpu_rx_pop removing the head. rx_irq is 1 while the queue holds a word, and rx_in_ready is 0 when it is full, in which case the offered word is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dw_valid | input | 1 | Descriptor write request |
| dw_idx | input | 3 | Descriptor slot to write |
| dw_data | input | 64 | Descriptor write data |
| dw_hold | output | 1 | Descriptor write stalled |
| launch_valid | input | 1 | Launch command |
| launch_len | input | 4 | Descriptor slots used |
| launch_nexp | input | 4 | Explicit words, header included |
| user_mode | input | 1 | Launch issued from user mode |
| launch_ready | output | 1 | Launcher idle, launch accepted |
| launch_fault | output | 1 | One-cycle pulse on a rejected launch |
| mem_addr | output | 32 | Memory word address for block fetch |
| mem_rdata | input | 64 | Memory word at mem_addr, same cycle |
| out_valid | output | 1 | Outgoing word valid |
| out_ready | input | 1 | Network accepts the word |
| out_data | output | 64 | Outgoing word |
| out_last | output | 1 | Final word of the message |
| rx_in_valid | input | 1 | Incoming word offered |
| rx_in_data | input | 64 | Incoming word |
| rx_in_ready | output | 1 | Receive queue has room |
| rx_irq | output | 1 | Receive queue not empty |
| cpu_rx_pop | input | 1 | Remove head of receive queue |
| cpu_rx_data | output | 64 | Head of receive queue |

## Verification
A launch accepted at one edge shows its first word on out_valid/out_data one cycle later, and a rejected launch shows launch_fault in that same cycle, for exactly one cycle. The bench drives inputs on the falling edge and samples one time unit after it, so each result is read in the first cycle it is due. Words are counted as transferred only when valid and ready are both high at the edge that follows the sample. The cycle after the final word must show out_valid low, and a receive push shows rx_irq on the cycle after its edge.

// File: rtl/msg_pkg.sv
package msg_pkg;
  localparam int DW     = 64;
  localparam int DEPTH  = 8;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int PLEN_W = 8;
  localparam int ADDR_W = 32;
  localparam int TOT_W  = CNT_W + PLEN_W + 2;
  localparam int OP_LSB = 56;
  localparam int OP_W   = 8;

  typedef logic [DEPTH-1:0][DW-1:0] desc_arr_t;
  typedef enum logic [1:0] {ST_IDLE, ST_EXP, ST_PAIR, ST_DMA} lst_t;

  function automatic logic [OP_W-1:0] hdr_op(input logic [DW-1:0] w);
    return w[OP_LSB +: OP_W];
  endfunction

  function automatic logic op_is_priv(input logic [OP_W-1:0] op,
                                      input logic [OP_W-1:0] base);
    return op >= base;
  endfunction

  function automatic logic desc_ok(input logic [CNT_W-1:0] len,
                                   input logic [CNT_W-1:0] nexp);
    logic [CNT_W-1:0] rest;
    rest = len - nexp;
    return (nexp != '0) && (nexp <= len) && (int'(len) <= DEPTH) && !rest[0];
  endfunction

  function automatic logic [TOT_W-1:0] total_words(input desc_arr_t d,
                                                   input logic [CNT_W-1:0] len,
                                                   input logic [CNT_W-1:0] nexp);
    int sum;
    sum = int'(nexp);
    for (int i = 0; i < DEPTH; i++) begin
      if (i > int'(nexp) && i < int'(len) && ((i - int'(nexp)) % 2 == 1))
        sum += int'(d[i][PLEN_W-1:0]);
    end
    return TOT_W'(sum);
  endfunction
endpackage

// File: rtl/msg_desc_regs.sv
module msg_desc_regs
  import msg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             busy,
  input  logic             launch_pending,
  output logic             wr_hold,
  output logic             wr_fire,
  output desc_arr_t        desc
);
  assign wr_hold = busy | launch_pending;
  assign wr_fire = wr_valid & ~wr_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) desc <= '0;
    else if (wr_fire) desc[wr_idx] <= wr_data;
  end
endmodule

// File: rtl/msg_launch_ctrl.sv
module msg_launch_ctrl
  import msg_pkg::*;
#(
  parameter logic [OP_W-1:0] PRIV_BASE = 8'hC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  desc_arr_t         desc,
  input  logic              wr_fire,
  input  logic              launch_valid,
  input  logic [CNT_W-1:0]  launch_len,
  input  logic [CNT_W-1:0]  launch_nexp,
  input  logic              user_mode,
  output logic              launch_ready,
  output logic              launch_fault,
  output logic              busy,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DW-1:0]     mem_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  output logic              out_last
);
  lst_t              state;
  logic [CNT_W-1:0]  idx, len_q, nexp_q;
  logic [TOT_W-1:0]  left;
  logic [ADDR_W-1:0] dma_addr;
  logic [PLEN_W-1:0] dma_rem;

  logic             take, hdr_priv, shape_ok, accept_ok, reject, beat;
  logic [IDX_W-1:0] slot, slot_n;
  logic [CNT_W-1:0] idx_inc;

  assign busy         = (state != ST_IDLE);
  assign launch_ready = ~busy;
  assign take         = launch_valid & launch_ready;
  assign hdr_priv     = op_is_priv(hdr_op(desc[0]), PRIV_BASE);
  assign shape_ok     = desc_ok(launch_len, launch_nexp);
  assign accept_ok    = take & shape_ok & ~(user_mode & hdr_priv);
  assign reject       = take & ~accept_ok;

  assign idx_inc  = idx + CNT_W'(1);
  assign slot     = idx[IDX_W-1:0];
  assign slot_n   = idx_inc[IDX_W-1:0];

  assign out_valid = (state == ST_EXP) || (state == ST_DMA);
  assign out_data  = (state == ST_DMA) ? mem_rdata : desc[slot];
  assign out_last  = out_valid && (left == TOT_W'(1));
  assign mem_addr  = dma_addr;
  assign beat      = out_valid & out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      idx          <= '0;
      len_q        <= '0;
      nexp_q       <= '0;
      left         <= '0;
      dma_addr     <= '0;
      dma_rem      <= '0;
      launch_fault <= 1'b0;
    end else begin
      launch_fault <= reject;
      case (state)
        ST_IDLE: begin
          if (accept_ok) begin
            state  <= ST_EXP;
            idx    <= '0;
            len_q  <= launch_len;
            nexp_q <= launch_nexp;
            left   <= total_words(desc, launch_len, launch_nexp);
          end
        end
        ST_EXP: begin
          if (beat) begin
            left <= left - TOT_W'(1);
            idx  <= idx_inc;
            if (left == TOT_W'(1)) state <= ST_IDLE;
            else if (idx_inc == nexp_q) state <= ST_PAIR;
          end
        end
        ST_PAIR: begin
          if (idx >= len_q) begin
            state <= ST_IDLE;
          end else begin
            dma_addr <= desc[slot][ADDR_W-1:0];
            dma_rem  <= desc[slot_n][PLEN_W-1:0];
            idx      <= idx + CNT_W'(2);
            if (desc[slot_n][PLEN_W-1:0] != '0) state <= ST_DMA;
          end
        end
        ST_DMA: begin
          if (beat) begin
            left     <= left - TOT_W'(1);
            dma_addr <= dma_addr + ADDR_W'(1);
            dma_rem  <= dma_rem - PLEN_W'(1);
            if (left == TOT_W'(1)) state <= ST_IDLE;
            else if (dma_rem == PLEN_W'(1)) state <= ST_PAIR;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  last_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);

  // R6
  priv_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_valid && launch_ready && user_mode &&
     op_is_priv(hdr_op(desc[0]), PRIV_BASE)) |=> (launch_fault && !out_valid));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_last) && $stable(mem_addr)));

  // R8
  busy_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_fire);

  // R7
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_fault |-> !out_valid);
endmodule

// File: rtl/msg_rx_stub.sv
module msg_rx_stub #(
  parameter int RX_DEPTH = 4,
  parameter int DW       = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          irq,
  input  logic          pop,
  output logic [DW-1:0] head
);
  localparam int PW = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1;
  localparam int CW = $clog2(RX_DEPTH + 1);

  logic [DW-1:0] q [RX_DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          push, take;

  assign in_ready = (cnt != CW'(RX_DEPTH));
  assign irq      = (cnt != '0);
  assign push     = in_valid & in_ready;
  assign take     = pop & irq;
  assign head     = q[rptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (int'(p) == RX_DEPTH - 1) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      for (int i = 0; i < RX_DEPTH; i++) q[i] <= '0;
    end else begin
      if (push) begin
        q[wptr] <= in_data;
        wptr    <= bump(wptr);
      end
      if (take) rptr <= bump(rptr);
      cnt <= cnt + CW'(push) - CW'(take);
    end
  end

  // R10
  rx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !take) |=> irq);

  // R10
  rx_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !push) |=> in_ready);
endmodule

// File: rtl/msg_launcher.sv
module msg_launcher
  import msg_pkg::*;
#(
  parameter logic [OP_W-1:0] PRIV_BASE = 8'hC0,
  parameter int              RX_DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dw_valid,
  input  logic [IDX_W-1:0]  dw_idx,
  input  logic [DW-1:0]     dw_data,
  output logic              dw_hold,
  input  logic              launch_valid,
  input  logic [CNT_W-1:0]  launch_len,
  input  logic [CNT_W-1:0]  launch_nexp,
  input  logic              user_mode,
  output logic              launch_ready,
  output logic              launch_fault,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DW-1:0]     mem_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  output logic              out_last,
  input  logic              rx_in_valid,
  input  logic [DW-1:0]     rx_in_data,
  output logic              rx_in_ready,
  output logic              rx_irq,
  input  logic              cpu_rx_pop,
  output logic [DW-1:0]     cpu_rx_data
);
  desc_arr_t desc;
  logic      busy, wr_fire;

  msg_desc_regs u_desc (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_valid       (dw_valid),
    .wr_idx         (dw_idx),
    .wr_data        (dw_data),
    .busy           (busy),
    .launch_pending (launch_valid),
    .wr_hold        (dw_hold),
    .wr_fire        (wr_fire),
    .desc           (desc)
  );

  msg_launch_ctrl #(.PRIV_BASE(PRIV_BASE)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .desc         (desc),
    .wr_fire      (wr_fire),
    .launch_valid (launch_valid),
    .launch_len   (launch_len),
    .launch_nexp  (launch_nexp),
    .user_mode    (user_mode),
    .launch_ready (launch_ready),
    .launch_fault (launch_fault),
    .busy         (busy),
    .mem_addr     (mem_addr),
    .mem_rdata    (mem_rdata),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_last     (out_last)
  );

  msg_rx_stub #(.RX_DEPTH(RX_DEPTH), .DW(DW)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (rx_in_valid),
    .in_data  (rx_in_data),
    .in_ready (rx_in_ready),
    .irq      (rx_irq),
    .pop      (cpu_rx_pop),
    .head     (cpu_rx_data)
  );
endmodule

// File: tb/tb_msg_launcher.sv
`timescale 1ns/1ps
module tb_msg_launcher;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dw_valid = 1'b0;
  logic [2:0]  dw_idx = '0;
  logic [63:0] dw_data = '0;
  logic        dw_hold;
  logic        launch_valid = 1'b0;
  logic [3:0]  launch_len = '0, launch_nexp = '0;
  logic        user_mode = 1'b0;
  logic        launch_ready, launch_fault;
  logic [31:0] mem_addr;
  logic [63:0] mem_rdata;
  logic        out_valid, out_last;
  logic        out_ready = 1'b0;
  logic [63:0] out_data;
  logic        rx_in_valid = 1'b0;
  logic [63:0] rx_in_data = '0;
  logic        rx_in_ready, rx_irq;
  logic        cpu_rx_pop = 1'b0;
  logic [63:0] cpu_rx_data;

  int n_vec = 0, n_bad = 0;
  logic [63:0] sh [8];
  logic [63:0] exp_q [$];
  logic [63:0] got_q [$];
  int          last_pos;

  always #2 clk = ~clk;

  function automatic logic [63:0] memw(input logic [31:0] a);
    return {~a, a};
  endfunction
  assign mem_rdata = memw(mem_addr);

  function automatic logic [63:0] hdr(input logic [7:0] op, input logic [15:0] dest);
    return {op, 40'h0, dest};
  endfunction

  msg_launcher dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wr(input int i, input logic [63:0] d);
    @(negedge clk);
    dw_valid = 1'b1; dw_idx = 3'(i); dw_data = d;
    @(negedge clk);
    dw_valid = 1'b0;
    sh[i] = d;
  endtask

  task automatic launch(input int len, input int nexp, input bit usr);
    @(negedge clk);
    launch_valid = 1'b1; launch_len = 4'(len); launch_nexp = 4'(nexp); user_mode = usr;
    #1 chk(dw_hold == 1'b1, "R8 hold during launch_valid", 64'(dw_hold), 64'd1);
    @(negedge clk);
    launch_valid = 1'b0; user_mode = 1'b0;
  endtask

  task automatic build_exp(input int len, input int nexp);
    exp_q.delete();
    for (int i = 0; i < nexp; i++) exp_q.push_back(sh[i]);
    for (int i = nexp; i + 1 < len; i += 2)
      for (int k = 0; k < int'(sh[i+1][7:0]); k++) exp_q.push_back(memw(sh[i][31:0] + 32'(k)));
  endtask

  task automatic collect(input bit stutter);
    int cyc = 0;
    got_q.delete(); last_pos = -1;
    forever begin
      out_ready = stutter ? ((cyc % 3) != 1) : 1'b1;
      #1;
      if (out_valid && out_ready) begin
        got_q.push_back(out_data);
        if (out_last) last_pos = got_q.size() - 1;
      end
      if (last_pos >= 0 || cyc > 1000) break;
      @(negedge clk);
      cyc++;
    end
    @(negedge clk);
    out_ready = 1'b0;
    #1 chk(out_valid == 1'b0, "R5 no word after last", 64'(out_valid), 64'd0);
  endtask

  task automatic compare(input string req);
    chk(got_q.size() == exp_q.size(), {req, " word count"}, 64'(got_q.size()), 64'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    chk(last_pos == exp_q.size() - 1, "R5 last flag position", 64'(last_pos), 64'(exp_q.size() - 1));
  endtask

  task automatic t_reset();
    #1;
    chk(out_valid == 0, "R1 out_valid", 64'(out_valid), 0);
    chk(launch_fault == 0, "R1 launch_fault", 64'(launch_fault), 0);
    chk(rx_irq == 0, "R1 rx_irq", 64'(rx_irq), 0);
    chk(dw_hold == 0, "R1 dw_hold", 64'(dw_hold), 0);
    chk(launch_ready == 1, "R1 launch_ready", 64'(launch_ready), 1);
    for (int i = 0; i < 8; i++) sh[i] = '0;
    launch(8, 8, 1'b0);
    chk(out_valid == 1, "R3 valid one cycle after launch", 64'(out_valid), 1);
    build_exp(8, 8);
    collect(1'b0);
    compare("R1 slots zero after reset");
  endtask

  task automatic t_explicit();
    wr(0, hdr(8'h10, 16'h0042));
    wr(1, 64'h1111_2222_3333_4444);
    wr(2, 64'hDEAD_BEEF_0000_0001);
    launch(3, 3, 1'b1);
    chk(out_data == sh[0], "R3 header first", out_data, sh[0]);
    build_exp(3, 3);
    collect(1'b0);
    compare("R3 explicit words R2");
  endtask

  task automatic t_pairs();
    wr(0, hdr(8'h21, 16'h0007));
    wr(1, 64'h100); wr(2, 64'h3);
    wr(3, 64'h200); wr(4, 64'h0);
    wr(5, 64'h300); wr(6, 64'h2);
    launch(7, 1, 1'b0);
    build_exp(7, 1);
    collect(1'b0);
    compare("R4 pair expansion zero middle");
    wr(1, 64'hAAAA); wr(2, 64'h5);
    wr(3, 64'h400); wr(4, 64'h0);
    launch(5, 1, 1'b0);
    build_exp(5, 1);
    collect(1'b1);
    compare("R9 stutter with trailing zero pair R4");
  endtask

  task automatic t_priv();
    wr(0, hdr(8'hC3, 16'h0001));
    wr(1, 64'h77);
    launch(2, 2, 1'b1);
    chk(launch_fault == 1, "R6 fault pulse", 64'(launch_fault), 1);
    chk(out_valid == 0, "R6 nothing sent", 64'(out_valid), 0);
    @(negedge clk); #1;
    chk(launch_fault == 0, "R6 fault one cycle", 64'(launch_fault), 0);
    chk(out_valid == 0, "R6 still nothing", 64'(out_valid), 0);
    launch(2, 2, 1'b0);
    chk(launch_fault == 0, "R6 supervisor no fault", 64'(launch_fault), 0);
    build_exp(2, 2);
    collect(1'b0);
    compare("R6 supervisor sends");
    wr(0, hdr(8'hBF, 16'h0001));
    launch(2, 2, 1'b1);
    chk(launch_fault == 0, "R6 opcode below base", 64'(launch_fault), 0);
    build_exp(2, 2);
    collect(1'b0);
    compare("R6 user below base sends");
  endtask

  task automatic t_malformed();
    int lens [4] = '{3, 2, 5, 9};
    int nexs [4] = '{0, 3, 2, 1};
    wr(0, hdr(8'h05, 16'h0002));
    for (int k = 0; k < 4; k++) begin
      launch(lens[k], nexs[k], 1'b0);
      chk(launch_fault == 1, "R7 malformed fault", 64'(launch_fault), 1);
      chk(out_valid == 0, "R7 nothing sent", 64'(out_valid), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_busy();
    logic [63:0] keep;
    wr(0, hdr(8'h33, 16'h0009));
    wr(1, 64'h5555_6666);
    keep = sh[1];
    launch(2, 2, 1'b0);
    #1;
    chk(dw_hold == 1, "R8 hold while busy", 64'(dw_hold), 1);
    chk(launch_ready == 0, "R8 not ready while busy", 64'(launch_ready), 0);
    @(negedge clk);
    dw_valid = 1'b1; dw_idx = 3'd1; dw_data = 64'hBAD0_BAD0;
    launch_valid = 1'b1; launch_len = 4'd1; launch_nexp = 4'd1;
    repeat (2) @(negedge clk);
    dw_valid = 1'b0; launch_valid = 1'b0;
    #1 chk(out_data == sh[0], "R9 word held under stall", out_data, sh[0]);
    sh[1] = keep;
    build_exp(2, 2);
    collect(1'b0);
    compare("R8 message unchanged by blocked write");
    launch(2, 2, 1'b0);
    collect(1'b0);
    compare("R8 blocked write dropped");
  endtask

  task automatic t_rx();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      #1 chk(rx_in_ready == (i < 4), "R10 ready vs fill", 64'(rx_in_ready), 64'(i < 4));
      rx_in_valid = 1'b1; rx_in_data = 64'hF000 + 64'(i);
      @(negedge clk);
      rx_in_valid = 1'b0;
      #1 chk(rx_irq == 1, "R10 irq when queued", 64'(rx_irq), 1);
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      #1 chk(cpu_rx_data == 64'hF000 + 64'(i), "R10 order", cpu_rx_data, 64'hF000 + 64'(i));
      cpu_rx_pop = 1'b1;
      @(negedge clk);
      cpu_rx_pop = 1'b0;
    end
    #1 chk(rx_irq == 0, "R10 irq clears, full word dropped", 64'(rx_irq), 0);
  endtask

  initial begin
    fork
      begin
        repeat (50000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_explicit();
    t_pairs();
    t_priv();
    t_malformed();
    t_busy();
    t_rx();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule